// File: doc/BRIEF.md
# LCD Panel Configuration Sequencer

This block brings a small TFT panel up and down and programs its control registers through a write-only serial link. It drives three things: the supply enable, the active-low panel reset and the three serial lines (clock, data, chip select). A power-on request turns the supply on and holds reset low while the supply settles. It then releases reset and sends a fixed train of register writes: the scan mode, the operating control word, two auxiliary words, the mirror register and the packed gamma table.

Once the panel is running, the host can change three settings through independent valid/ready handshakes: the scan mode, the two mirror flags and the twelve gamma points. Each accepted change is stored and sent to the panel at once. The stored settings are replayed on every later power-on. A power-off request puts the panel into standby in stages. It sends a dimmed control word, drops reset, waits for the panel to finish its frames, sends the final standby word and then removes the supply.

Every serial frame is one 16-bit word, sent most significant bit first with the clock idling low. The settle and cool-down waits are counted in system clock cycles, derived from the clock frequency parameter.

Top module: `panel_cfg_seq`

## Requirements
- R1: Every write is one 16-bit frame, sent MSB first: bits [15:10] carry the register address, bit 9 is 0, bit 8 is 1 and bits [7:0] carry the data. The clock idles low and the data is stable around each rising edge. Chip select is low for exactly 16 rising clock edges, and stays high for at least one clock period (2·HALF_DIV system cycles) between frames.
- R2: After reset: supply_en=0, panel_rst_n=0, spi_cs_n=1, spi_sclk=0, busy=0 and panel_on=0. The stored settings are mode 7, both mirror flags off and the gamma points 106, 200, 289, 375, 460, 543, 625, 705, 785, 864, 942, 1020.
- R3: A power-on request from the off state raises supply_en on the next clock edge. panel_rst_n rises exactly CLK_HZ/1000·ON_MS cycles after supply_en. The 20 frames then follow in this order: 0x02, 0x03, 0x20, 0x21, 0x04, 0x11, 0x12, 0x13, 0x14 through 0x1F.
- R4: Register 0x02 carries 0x08 OR the 3-bit mode. A mode request whose value exceeds 7 is consumed by the handshake, but it sends no frame and leaves the stored mode unchanged.
- R5: During power-on, register 0x03 receives 0xDF, and registers 0x20 and 0x21 each receive 0xF0.
- R6: Register 0x04 receives 0x17, with bit 0 cleared when horizontal mirroring is on and bit 1 cleared when vertical mirroring is on.
- R7: Registers 0x11, 0x12 and 0x13 each carry bits [9:8] of four consecutive points, the lowest-numbered point in bits [7:6]. Registers 0x14 to 0x1F then carry bits [7:0] of points 0 to 11. An accepted gamma request sends these 15 frames in this order.
- R8: A power-off request from the active state sends 0x03=0xD8, then drops panel_rst_n, then waits CLK_HZ/1000·OFF_MS cycles. It then sends 0x03=0xD0 while supply_en is still high, and lowers supply_en after that frame.
- R9: A power-on request while the panel is active, or a power-off request while it is off, produces no frame and no change of the outputs.
- R10: mode_ready, mirror_ready and gamma_ready are high only when panel_on is high. Among the pending requests, power-off takes precedence, then mode, then mirror, then gamma. Accepted settings persist into the next power-on.
- R11: busy is high from the clock edge that accepts any request until its sequence ends. panel_on is high only in the active idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | Request to power the panel up |
| pwr_off_req | input | 1 | Request to power the panel down |
| mode_valid | input | 1 | Mode change request valid |
| mode_in | input | MODE_IN_W | Requested scan mode |
| mode_ready | output | 1 | Mode request accepted this cycle |
| mirror_valid | input | 1 | Mirror change request valid |
| mirror_h | input | 1 | Horizontal mirroring on |
| mirror_v | input | 1 | Vertical mirroring on |
| mirror_ready | output | 1 | Mirror request accepted this cycle |
| gamma_valid | input | 1 | Gamma table request valid |
| gamma_in | input | 120 | Twelve 10-bit points, point i at bits [10i+9:10i] |
| gamma_ready | output | 1 | Gamma request accepted this cycle |
| supply_en | output | 1 | Panel supply enable |
| panel_rst_n | output | 1 | Active-low panel reset |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data |
| spi_cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | A sequence or frame is in progress |
| panel_on | output | 1 | Panel active and sequencer idle |

## Verification
The assertions assume that every request input changes only away from the active clock edge. They also assume that a valid signal, together with its payload, is held until the matching ready is seen and then dropped in the following cycle. The bench drives all inputs on the falling clock edge and keeps each valid up until it has sampled ready. It drives the power requests as single-cycle pulses. It reconstructs every frame from the serial lines alone and derives the expected register contents from the stored settings it has sent.

// File: rtl/panel_cfg_pkg.sv
package panel_cfg_pkg;

    // frame layout
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = ADDR_W + 2 + DATA_W;

    // gamma table shape
    localparam int GAMMA_N     = 12;
    localparam int GAMMA_W     = 10;
    localparam int PTS_PER_REG = 4;
    localparam int HI_REGS     = GAMMA_N / PTS_PER_REG;
    localparam int HI_IDX_W    = $clog2(HI_REGS);
    localparam int LO_IDX_W    = $clog2(GAMMA_N);

    typedef logic [GAMMA_N*GAMMA_W-1:0] gamma_vec_t;

    // step map of the write train
    localparam int STEP_W = 5;
    localparam logic [STEP_W-1:0] STEP_MODE    = STEP_W'(0);
    localparam logic [STEP_W-1:0] STEP_CTRL    = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_AUX0    = STEP_W'(2);
    localparam logic [STEP_W-1:0] STEP_AUX1    = STEP_W'(3);
    localparam logic [STEP_W-1:0] STEP_MIRROR  = STEP_W'(4);
    localparam logic [STEP_W-1:0] STEP_HI0     = STEP_W'(5);
    localparam logic [STEP_W-1:0] STEP_LO0     = STEP_W'(5 + HI_REGS);
    localparam logic [STEP_W-1:0] STEP_ON_LAST = STEP_W'(5 + HI_REGS + GAMMA_N - 1);
    localparam logic [STEP_W-1:0] STEP_OFF_A   = STEP_W'(5 + HI_REGS + GAMMA_N);
    localparam logic [STEP_W-1:0] STEP_OFF_B   = STEP_W'(6 + HI_REGS + GAMMA_N);

    // register addresses
    localparam logic [ADDR_W-1:0] A_MODE   = 6'h02;
    localparam logic [ADDR_W-1:0] A_CTRL   = 6'h03;
    localparam logic [ADDR_W-1:0] A_MIRROR = 6'h04;
    localparam logic [ADDR_W-1:0] A_GHI0   = 6'h11;
    localparam logic [ADDR_W-1:0] A_GLO0   = 6'h14;
    localparam logic [ADDR_W-1:0] A_AUX0   = 6'h20;
    localparam logic [ADDR_W-1:0] A_AUX1   = 6'h21;

    // register values
    localparam logic [DATA_W-1:0] D_CTRL_RUN   = 8'hDF;
    localparam logic [DATA_W-1:0] D_CTRL_DIM   = 8'hD8;
    localparam logic [DATA_W-1:0] D_CTRL_STBY  = 8'hD0;
    localparam logic [DATA_W-1:0] D_AUX        = 8'hF0;
    localparam logic [DATA_W-1:0] D_MIRROR_BASE = 8'h17;
    localparam logic [4:0]        D_MODE_HIGH  = 5'b00001;

    localparam logic [2:0] MODE_RESET = 3'd7;

    typedef enum logic [2:0] {
        ST_OFF, ST_SETTLE, ST_SEND, ST_WAIT_TX, ST_ACTIVE, ST_COOL
    } seq_st_e;

    typedef enum logic [1:0] {
        TX_IDLE, TX_SHIFT, TX_GAP
    } tx_st_e;

    function automatic logic [GAMMA_W-1:0] gamma_point_default(input int idx);
        case (idx)
            0:  return GAMMA_W'(106);
            1:  return GAMMA_W'(200);
            2:  return GAMMA_W'(289);
            3:  return GAMMA_W'(375);
            4:  return GAMMA_W'(460);
            5:  return GAMMA_W'(543);
            6:  return GAMMA_W'(625);
            7:  return GAMMA_W'(705);
            8:  return GAMMA_W'(785);
            9:  return GAMMA_W'(864);
            10: return GAMMA_W'(942);
            default: return GAMMA_W'(1020);
        endcase
    endfunction

    function automatic gamma_vec_t gamma_table_default();
        gamma_vec_t v;
        v = '0;
        for (int i = 0; i < GAMMA_N; i++) begin
            v[i*GAMMA_W +: GAMMA_W] = gamma_point_default(i);
        end
        return v;
    endfunction

endpackage

// File: rtl/panel_ms_timer.sv
module panel_ms_timer #(
    parameter int ON_CYC  = 1000,
    parameter int OFF_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sel_off,
    output logic done
);
    localparam int MAX_CYC = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = 1'b0;
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = sel_off ? CNT_W'(OFF_CYC - 1) : CNT_W'(ON_CYC - 1);
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                done      = 1'b1;
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/panel_spi_tx.sv
module panel_spi_tx
    import panel_cfg_pkg::*;
#(
    parameter int HALF_DIV   = 4,
    parameter int GAP_HALVES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] word,
    output logic               done,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n
);
    localparam int DIV_W   = $clog2(HALF_DIV + 1);
    localparam int CNT_TOP = (FRAME_W > GAP_HALVES) ? FRAME_W : GAP_HALVES;
    localparam int BIT_W   = $clog2(CNT_TOP + 1);

    typedef struct packed {
        tx_st_e             st;
        logic [DIV_W-1:0]   div;
        logic [BIT_W-1:0]   bits;
        logic               sclk;
        logic               cs_n;
        logic [FRAME_W-1:0] sh;
    } tx_t;

    tx_t tx_d, tx_q;
    logic half_tick;

    assign half_tick = (tx_q.div == DIV_W'(HALF_DIV - 1));

    always_comb begin
        tx_d = tx_q;
        done = 1'b0;
        case (tx_q.st)
            TX_IDLE: begin
                if (start) begin
                    tx_d.st   = TX_SHIFT;
                    tx_d.cs_n = 1'b0;
                    tx_d.sh   = word;
                    tx_d.div  = '0;
                    tx_d.bits = '0;
                    tx_d.sclk = 1'b0;
                end
            end
            TX_SHIFT: begin
                if (half_tick) begin
                    tx_d.div = '0;
                    if (!tx_q.sclk) begin
                        tx_d.sclk = 1'b1;
                    end else begin
                        tx_d.sclk = 1'b0;
                        if (tx_q.bits == BIT_W'(FRAME_W - 1)) begin
                            tx_d.st   = TX_GAP;
                            tx_d.cs_n = 1'b1;
                            tx_d.bits = '0;
                        end else begin
                            tx_d.bits = tx_q.bits + 1'b1;
                            tx_d.sh   = {tx_q.sh[FRAME_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    tx_d.div = tx_q.div + 1'b1;
                end
            end
            TX_GAP: begin
                if (half_tick) begin
                    tx_d.div = '0;
                    if (tx_q.bits == BIT_W'(GAP_HALVES - 1)) begin
                        tx_d.st   = TX_IDLE;
                        tx_d.bits = '0;
                        done      = 1'b1;
                    end else begin
                        tx_d.bits = tx_q.bits + 1'b1;
                    end
                end else begin
                    tx_d.div = tx_q.div + 1'b1;
                end
            end
            default: tx_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q      <= '0;
            tx_q.st   <= TX_IDLE;
            tx_q.cs_n <= 1'b1;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign sclk = tx_q.sclk;
    assign cs_n = tx_q.cs_n;
    assign mosi = tx_q.sh[FRAME_W-1];
endmodule

// File: rtl/panel_frame_rom.sv
module panel_frame_rom
    import panel_cfg_pkg::*;
(
    input  logic [STEP_W-1:0]  step,
    input  logic [2:0]         mode,
    input  logic               mir_h,
    input  logic               mir_v,
    input  gamma_vec_t         gamma,
    output logic [FRAME_W-1:0] frame
);
    logic [HI_REGS-1:0][DATA_W-1:0] hi_byte;
    logic [ADDR_W-1:0]              addr;
    logic [DATA_W-1:0]              data;
    logic [STEP_W-1:0]              hi_off;
    logic [STEP_W-1:0]              lo_off;
    logic [HI_IDX_W-1:0]            hi_idx;
    logic [LO_IDX_W-1:0]            lo_idx;

    // top bits of four consecutive points per register, lowest point highest
    for (genvar g = 0; g < HI_REGS; g++) begin : g_hi
        for (genvar k = 0; k < PTS_PER_REG; k++) begin : g_pt
            assign hi_byte[g][DATA_W-1-2*k -: 2] =
                gamma[(PTS_PER_REG*g + k)*GAMMA_W + 8 +: 2];
        end
    end

    assign hi_off = step - STEP_HI0;
    assign lo_off = step - STEP_LO0;
    assign hi_idx = hi_off[HI_IDX_W-1:0];
    assign lo_idx = lo_off[LO_IDX_W-1:0];

    always_comb begin
        addr = '0;
        data = '0;
        if (step == STEP_MODE) begin
            addr = A_MODE;
            data = {D_MODE_HIGH, mode};
        end else if (step == STEP_CTRL) begin
            addr = A_CTRL;
            data = D_CTRL_RUN;
        end else if (step == STEP_AUX0) begin
            addr = A_AUX0;
            data = D_AUX;
        end else if (step == STEP_AUX1) begin
            addr = A_AUX1;
            data = D_AUX;
        end else if (step == STEP_MIRROR) begin
            addr = A_MIRROR;
            data = D_MIRROR_BASE & ~{6'b0, mir_v, mir_h};
        end else if (step >= STEP_HI0 && step < STEP_LO0) begin
            addr = A_GHI0 + ADDR_W'(hi_off);
            data = hi_byte[hi_idx];
        end else if (step >= STEP_LO0 && step <= STEP_ON_LAST) begin
            addr = A_GLO0 + ADDR_W'(lo_off);
            data = gamma[lo_idx*GAMMA_W +: DATA_W];
        end else if (step == STEP_OFF_A) begin
            addr = A_CTRL;
            data = D_CTRL_DIM;
        end else if (step == STEP_OFF_B) begin
            addr = A_CTRL;
            data = D_CTRL_STBY;
        end
    end

    assign frame = {addr, 2'b01, data};
endmodule

// File: rtl/panel_cfg_seq.sv
module panel_cfg_seq
    import panel_cfg_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int ON_MS      = 160,
    parameter int OFF_MS     = 50,
    parameter int HALF_DIV   = 4,
    parameter int GAP_HALVES = 2,
    parameter int MODE_IN_W  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pwr_on_req,
    input  logic                         pwr_off_req,
    input  logic                         mode_valid,
    input  logic [MODE_IN_W-1:0]         mode_in,
    output logic                         mode_ready,
    input  logic                         mirror_valid,
    input  logic                         mirror_h,
    input  logic                         mirror_v,
    output logic                         mirror_ready,
    input  logic                         gamma_valid,
    input  logic [GAMMA_N*GAMMA_W-1:0]   gamma_in,
    output logic                         gamma_ready,
    output logic                         supply_en,
    output logic                         panel_rst_n,
    output logic                         spi_sclk,
    output logic                         spi_mosi,
    output logic                         spi_cs_n,
    output logic                         busy,
    output logic                         panel_on
);
    localparam int CYC_PER_MS = CLK_HZ / 1000;
    localparam int ON_CYC     = CYC_PER_MS * ON_MS;
    localparam int OFF_CYC    = CYC_PER_MS * OFF_MS;

    typedef struct packed {
        seq_st_e           st;
        logic [STEP_W-1:0] step;
        logic [STEP_W-1:0] last;
        logic [2:0]        mode;
        logic              mir_h;
        logic              mir_v;
        gamma_vec_t        gamma;
        logic              supply;
        logic              prst_n;
    } seq_t;

    seq_t seq_d, seq_q;

    logic               tx_start, tx_done;
    logic               tmr_start, tmr_sel_off, tmr_done;
    logic [FRAME_W-1:0] frame;
    logic               mode_bad;

    assign mode_bad = |mode_in[MODE_IN_W-1:3];

    always_comb begin
        seq_d        = seq_q;
        tx_start     = 1'b0;
        tmr_start    = 1'b0;
        tmr_sel_off  = 1'b0;
        mode_ready   = 1'b0;
        mirror_ready = 1'b0;
        gamma_ready  = 1'b0;
        case (seq_q.st)
            ST_OFF: begin
                if (pwr_on_req) begin
                    seq_d.supply = 1'b1;
                    seq_d.st     = ST_SETTLE;
                    tmr_start    = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_done) begin
                    seq_d.prst_n = 1'b1;
                    seq_d.step   = STEP_MODE;
                    seq_d.last   = STEP_ON_LAST;
                    seq_d.st     = ST_SEND;
                end
            end
            ST_SEND: begin
                tx_start = 1'b1;
                seq_d.st = ST_WAIT_TX;
            end
            ST_WAIT_TX: begin
                if (tx_done) begin
                    if (seq_q.step != seq_q.last) begin
                        seq_d.step = seq_q.step + 1'b1;
                        seq_d.st   = ST_SEND;
                    end else if (seq_q.last == STEP_OFF_A) begin
                        seq_d.prst_n = 1'b0;
                        seq_d.st     = ST_COOL;
                        tmr_start    = 1'b1;
                        tmr_sel_off  = 1'b1;
                    end else if (seq_q.last == STEP_OFF_B) begin
                        seq_d.supply = 1'b0;
                        seq_d.st     = ST_OFF;
                    end else begin
                        seq_d.st = ST_ACTIVE;
                    end
                end
            end
            ST_COOL: begin
                if (tmr_done) begin
                    seq_d.step = STEP_OFF_B;
                    seq_d.last = STEP_OFF_B;
                    seq_d.st   = ST_SEND;
                end
            end
            ST_ACTIVE: begin
                if (pwr_off_req) begin
                    seq_d.step = STEP_OFF_A;
                    seq_d.last = STEP_OFF_A;
                    seq_d.st   = ST_SEND;
                end else if (mode_valid) begin
                    mode_ready = 1'b1;
                    if (!mode_bad) begin
                        seq_d.mode = mode_in[2:0];
                        seq_d.step = STEP_MODE;
                        seq_d.last = STEP_MODE;
                        seq_d.st   = ST_SEND;
                    end
                end else if (mirror_valid) begin
                    mirror_ready = 1'b1;
                    seq_d.mir_h  = mirror_h;
                    seq_d.mir_v  = mirror_v;
                    seq_d.step   = STEP_MIRROR;
                    seq_d.last   = STEP_MIRROR;
                    seq_d.st     = ST_SEND;
                end else if (gamma_valid) begin
                    gamma_ready = 1'b1;
                    seq_d.gamma = gamma_in;
                    seq_d.step  = STEP_HI0;
                    seq_d.last  = STEP_ON_LAST;
                    seq_d.st    = ST_SEND;
                end
            end
            default: seq_d.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q        <= '0;
            seq_q.st     <= ST_OFF;
            seq_q.mode   <= MODE_RESET;
            seq_q.gamma  <= gamma_table_default();
        end else begin
            seq_q <= seq_d;
        end
    end

    panel_frame_rom u_rom (
        .step  (seq_q.step),
        .mode  (seq_q.mode),
        .mir_h (seq_q.mir_h),
        .mir_v (seq_q.mir_v),
        .gamma (seq_q.gamma),
        .frame (frame)
    );

    panel_spi_tx #(
        .HALF_DIV   (HALF_DIV),
        .GAP_HALVES (GAP_HALVES)
    ) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_start),
        .word  (frame),
        .done  (tx_done),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .cs_n  (spi_cs_n)
    );

    panel_ms_timer #(
        .ON_CYC  (ON_CYC),
        .OFF_CYC (OFF_CYC)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .sel_off (tmr_sel_off),
        .done    (tmr_done)
    );

    assign supply_en   = seq_q.supply;
    assign panel_rst_n = seq_q.prst_n;
    assign busy        = (seq_q.st != ST_OFF) && (seq_q.st != ST_ACTIVE);
    assign panel_on    = (seq_q.st == ST_ACTIVE);
endmodule

// File: rtl/panel_cfg_seq_chk.sv
module panel_cfg_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_ready,
    input logic mirror_ready,
    input logic gamma_ready,
    input logic supply_en,
    input logic panel_rst_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n,
    input logic busy,
    input logic panel_on
);
    // R1
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R1
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R3
    reset_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        panel_rst_n |-> supply_en);

    // R8
    supply_drop_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_en) |-> !panel_rst_n);

    // R10
    ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_ready, mirror_ready, gamma_ready}));

    // R10
    ready_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ready || mirror_ready || gamma_ready) |-> (panel_on && !busy));

    // R11
    frame_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    // R11
    on_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        panel_on |-> !busy);
endmodule

bind panel_cfg_seq panel_cfg_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_ready   (mode_ready),
    .mirror_ready (mirror_ready),
    .gamma_ready  (gamma_ready),
    .supply_en    (supply_en),
    .panel_rst_n  (panel_rst_n),
    .spi_sclk     (spi_sclk),
    .spi_mosi     (spi_mosi),
    .spi_cs_n     (spi_cs_n),
    .busy         (busy),
    .panel_on     (panel_on)
);

// File: tb/panel_cfg_seq_tb.sv
module panel_cfg_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 10_000;
    localparam int ON_MS      = 160;
    localparam int OFF_MS     = 50;
    localparam int HALF_DIV   = 2;
    localparam int ON_CYC     = CLK_HZ / 1000 * ON_MS;
    localparam int OFF_CYC    = CLK_HZ / 1000 * OFF_MS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_on_req = 1'b0, pwr_off_req = 1'b0;
    logic mode_valid = 1'b0;
    logic [3:0] mode_in = '0;
    logic mode_ready;
    logic mirror_valid = 1'b0, mirror_h = 1'b0, mirror_v = 1'b0;
    logic mirror_ready;
    logic gamma_valid = 1'b0;
    logic [119:0] gamma_in = '0;
    logic gamma_ready;
    logic supply_en, panel_rst_n, spi_sclk, spi_mosi, spi_cs_n, busy, panel_on;

    int n_checks = 0;
    int n_errors = 0;

    // bench model of the stored settings
    logic [2:0] m_mode;
    logic       m_h, m_v;
    logic [9:0] m_pts [12];

    always #(CLK_PERIOD/2) clk = ~clk;

    panel_cfg_seq #(
        .CLK_HZ(CLK_HZ), .ON_MS(ON_MS), .OFF_MS(OFF_MS),
        .HALF_DIV(HALF_DIV), .GAP_HALVES(2), .MODE_IN_W(4)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
        .mode_valid(mode_valid), .mode_in(mode_in), .mode_ready(mode_ready),
        .mirror_valid(mirror_valid), .mirror_h(mirror_h), .mirror_v(mirror_v),
        .mirror_ready(mirror_ready),
        .gamma_valid(gamma_valid), .gamma_in(gamma_in), .gamma_ready(gamma_ready),
        .supply_en(supply_en), .panel_rst_n(panel_rst_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .busy(busy), .panel_on(panel_on)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // serial line monitor
    int          cyc = 0;
    int          last_rise = -1000;
    logic [15:0] cap_w [0:127];
    int          wcnt = 0;
    int          nbits = 0;
    logic [15:0] shreg = '0;
    bit          in_frame = 0;

    always @(posedge clk) cyc++;

    always @(negedge spi_cs_n) begin
        in_frame = 1;
        nbits    = 0;
        // R1 idle gap between frames
        check((cyc - last_rise) >= 2*HALF_DIV, "R1", "cs gap", cyc - last_rise, 2*HALF_DIV);
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            shreg = {shreg[14:0], spi_mosi};
            nbits++;
        end
    end

    always @(posedge spi_cs_n) begin
        if (in_frame) begin
            in_frame  = 0;
            last_rise = cyc;
            // R1 exactly sixteen clocks per frame
            check(nbits == 16, "R1", "bits per frame", nbits, 16);
            if (wcnt < 128) cap_w[wcnt] = shreg;
            wcnt++;
        end
    end

    function automatic logic [15:0] fw(input logic [5:0] a, input logic [7:0] d);
        return {a, 2'b01, d};
    endfunction

    function automatic logic [7:0] hi_pack(input int g);
        logic [7:0] v;
        for (int k = 0; k < 4; k++) v[7-2*k -: 2] = m_pts[4*g+k][9:8];
        return v;
    endfunction

    task automatic chk_word(input int idx, input logic [15:0] exp, input string req);
        check(idx < wcnt && cap_w[idx] == exp, req, $sformatf("frame %0d", idx),
              (idx < wcnt) ? cap_w[idx] : 16'hxxxx, exp);
    endtask

    task automatic chk_gamma_frames(input int base);
        for (int g = 0; g < 3; g++) chk_word(base + g, fw(6'h11 + 6'(g), hi_pack(g)), "R7");
        for (int i = 0; i < 12; i++) chk_word(base + 3 + i, fw(6'h14 + 6'(i), m_pts[i][7:0]), "R7");
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic pack_gamma();
        for (int i = 0; i < 12; i++) gamma_in[i*10 +: 10] = m_pts[i];
    endtask

    task automatic test_reset();
        check(supply_en == 0 && panel_rst_n == 0, "R2", "power pins", {supply_en, panel_rst_n}, 0);
        check(spi_cs_n == 1 && spi_sclk == 0, "R2", "serial idle", {spi_cs_n, spi_sclk}, 2);
        check(busy == 0 && panel_on == 0, "R2", "status", {busy, panel_on}, 0);
    endtask

    task automatic test_power_on();
        int base, n;
        base = wcnt;
        @(negedge clk) pwr_on_req = 1;
        @(negedge clk) pwr_on_req = 0;
        check(supply_en == 1 && panel_rst_n == 0, "R3", "supply first", {supply_en, panel_rst_n}, 2);
        check(busy == 1, "R11", "busy on accept", busy, 1);
        n = 0;
        while (!panel_rst_n && n < 5000) begin @(negedge clk); n++; end
        check(n == ON_CYC, "R3", "settle cycles", n, ON_CYC);
        wait_idle();
        check(wcnt - base == 20, "R3", "frame count", wcnt - base, 20);
        chk_word(base + 0, fw(6'h02, {5'b00001, m_mode}), "R4");
        chk_word(base + 1, fw(6'h03, 8'hDF), "R5");
        chk_word(base + 2, fw(6'h20, 8'hF0), "R5");
        chk_word(base + 3, fw(6'h21, 8'hF0), "R5");
        chk_word(base + 4, fw(6'h04, 8'h17 & ~{6'b0, m_v, m_h}), "R6");
        chk_gamma_frames(base + 5);
        check(panel_on == 1, "R11", "panel_on after power-on", panel_on, 1);
    endtask

    task automatic test_redundant_on();
        int base;
        base = wcnt;
        @(negedge clk) pwr_on_req = 1;
        @(negedge clk) pwr_on_req = 0;
        check(busy == 0 && panel_on == 1, "R9", "on while active", {busy, panel_on}, 1);
        repeat (50) @(negedge clk);
        check(wcnt == base, "R9", "no frame on repeat on", wcnt - base, 0);
    endtask

    task automatic test_mode();
        int base;
        base = wcnt;
        mode_in = 4'd3; mode_valid = 1;
        #1;
        check(mode_ready == 1, "R10", "mode ready", mode_ready, 1);
        @(negedge clk) mode_valid = 0;
        m_mode = 3'd3;
        wait_idle();
        check(wcnt - base == 1, "R4", "mode frame count", wcnt - base, 1);
        chk_word(base, fw(6'h02, 8'h0B), "R4");
        // rejected value
        base = wcnt;
        mode_in = 4'd9; mode_valid = 1;
        #1;
        check(mode_ready == 1, "R4", "bad mode consumed", mode_ready, 1);
        @(negedge clk) mode_valid = 0;
        repeat (100) @(negedge clk);
        check(wcnt == base && busy == 0, "R4", "bad mode no frame", wcnt - base, 0);
    endtask

    task automatic test_priority_mirror();
        int base;
        base = wcnt;
        mode_in = 4'd5; mode_valid = 1;
        mirror_h = 1; mirror_v = 0; mirror_valid = 1;
        #1;
        check(mode_ready == 1 && mirror_ready == 0, "R10", "mode before mirror",
              {mode_ready, mirror_ready}, 2);
        @(negedge clk) mode_valid = 0;
        m_mode = 3'd5;
        while (!mirror_ready) @(negedge clk);
        @(negedge clk) mirror_valid = 0;
        m_h = 1; m_v = 0;
        wait_idle();
        check(wcnt - base == 2, "R10", "two frames", wcnt - base, 2);
        chk_word(base, fw(6'h02, 8'h0D), "R4");
        chk_word(base + 1, fw(6'h04, 8'h16), "R6");
        base = wcnt;
        mirror_h = 1; mirror_v = 1; mirror_valid = 1;
        #1;
        @(negedge clk) mirror_valid = 0;
        m_v = 1;
        wait_idle();
        chk_word(base, fw(6'h04, 8'h14), "R6");
    endtask

    task automatic test_gamma();
        int base;
        base = wcnt;
        m_pts = '{10'd0, 10'd1023, 10'd512, 10'd256, 10'd768, 10'd100,
                  10'd900, 10'd300, 10'd700, 10'd1, 10'd1022, 10'd600};
        pack_gamma();
        gamma_valid = 1;
        #1;
        check(gamma_ready == 1, "R10", "gamma ready", gamma_ready, 1);
        @(negedge clk) gamma_valid = 0;
        wait_idle();
        check(wcnt - base == 15, "R7", "gamma frame count", wcnt - base, 15);
        chk_gamma_frames(base);
    endtask

    task automatic test_power_off();
        int base, n;
        base = wcnt;
        @(negedge clk) pwr_off_req = 1;
        @(negedge clk) pwr_off_req = 0;
        while (panel_rst_n) @(negedge clk);
        check(wcnt - base == 1 && supply_en == 1, "R8", "dim before reset", wcnt - base, 1);
        chk_word(base, fw(6'h03, 8'hD8), "R8");
        n = 0;
        while (spi_cs_n && n < 5000) begin @(negedge clk); n++; end
        check(n >= OFF_CYC && n <= OFF_CYC + 10, "R8", "cool cycles", n, OFF_CYC);
        check(supply_en == 1 && panel_rst_n == 0, "R8", "supply held", {supply_en, panel_rst_n}, 2);
        wait_idle();
        chk_word(base + 1, fw(6'h03, 8'hD0), "R8");
        check(supply_en == 0 && panel_on == 0, "R8", "supply off", {supply_en, panel_on}, 0);
    endtask

    task automatic test_off_idle();
        int base;
        base = wcnt;
        @(negedge clk) pwr_off_req = 1;
        @(negedge clk) pwr_off_req = 0;
        mode_in = 4'd1; mode_valid = 1; mirror_valid = 1; gamma_valid = 1;
        repeat (5) begin
            #1;
            check(!mode_ready && !mirror_ready && !gamma_ready, "R10", "no ready while off",
                  {mode_ready, mirror_ready, gamma_ready}, 0);
            @(negedge clk);
        end
        mode_valid = 0; mirror_valid = 0; gamma_valid = 0;
        repeat (50) @(negedge clk);
        check(wcnt == base && supply_en == 0 && busy == 0, "R9", "off while off", wcnt - base, 0);
    endtask

    initial begin
        m_mode = 3'd7; m_h = 0; m_v = 0;
        m_pts = '{10'd106, 10'd200, 10'd289, 10'd375, 10'd460, 10'd543,
                  10'd625, 10'd705, 10'd785, 10'd864, 10'd942, 10'd1020};
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        test_reset();
        test_power_on();       // defaults, R2 R3 R5 R6 R7
        test_redundant_on();
        test_mode();
        test_priority_mirror();
        test_gamma();
        test_power_off();
        test_off_idle();
        test_power_on();       // stored settings persist, R10
        test_power_off();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule